// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute step of a small RISC core. Each operation it accepts carries a 6-bit primary opcode, a 6-bit function code, a 5-bit shift amount, two register operand values (called rs and rt here) and the raw 16-bit immediate. The unit decodes two instruction formats. When the opcode is zero it is a register-register operation chosen by the function code. Otherwise it is a register-immediate operation chosen by the opcode. The unit returns the 32-bit result, a flag that asks for an overflow exception, and a flag that marks an unsupported encoding.

The arithmetic itself is combinational: decode, a logarithmic shifter, and an adder/comparator. One register slice sits at the output. Operations enter through a valid/ready handshake and results leave through another. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high, and its result appears on the outputs on that same edge. A result stays on the outputs, unchanged, until a rising edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle, so a full back-to-back stream runs at one operation per cycle. Branches, jumps, multiply/divide and writeback steering belong to other blocks.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals (not `out_valid`) or `out_ready`. An operation taken at an edge is presented with `out_valid`=1 right after that edge. While `out_valid`=1 and `out_ready`=0, all outputs hold unchanged.
- R3: `out_ovf` is 1 only for opcode 0 with function 32 (add), opcode 0 with function 34 (sub), or opcode 8 (add immediate), and only when the signed result overflows. An add overflows when both operands have one sign and the sum has the other. A subtract overflows when the operand signs differ and the difference's sign differs from rs. In every other case `out_ovf` is 0.
- R4: With opcode 0, functions 0, 2 and 3 shift rt by `in_shamt`: left, logical right and arithmetic right.
- R5: With opcode 0, functions 4, 6 and 7 shift rt by bits 4:0 of rs, in the same three directions. The higher bits of rs are ignored.
- R6: With opcode 0, functions 32 and 33 give rs+rt and functions 34 and 35 give rs−rt, both modulo 2^32. The wrapped value is the result even when overflow is flagged.
- R7: With opcode 0, functions 36, 37, 38 and 39 give the bitwise AND, OR, XOR and NOR of rs and rt.
- R8: With opcode 0, function 42 gives 1 if rs < rt as signed numbers and 0 otherwise. Function 43 does the same comparison unsigned. Bits 31:1 of such results are always 0.
- R9: Opcodes 8 (add, trapping), 9 (add, non-trapping), 10 (signed less-than) and 11 (unsigned less-than) use the sign-extended immediate in place of rt.
- R10: Opcodes 12, 13 and 14 give rs AND, OR and XOR with the zero-extended immediate.
- R11: Opcode 15 gives the immediate in bits 31:16 and zeros in bits 15:0. rs has no effect.
- R12: Any other opcode, or opcode 0 with a function not listed above, gives result 0, `out_illegal`=1 and `out_ovf`=0. Legal operations give `out_illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| in_opcode | input | 6 | Primary opcode |
| in_funct | input | 6 | Function code for register-register operations |
| in_shamt | input | 5 | Fixed shift amount |
| in_rs_val | input | 32 | First register operand |
| in_rt_val | input | 32 | Second register operand, and the value that shifts move |
| in_imm | input | 16 | Raw immediate field |
| out_valid | output | 1 | A result is held on the outputs |
| out_ready | input | 1 | The consumer takes the held result |
| out_result | output | 32 | Operation result |
| out_ovf | output | 1 | Signed-overflow exception request |
| out_illegal | output | 1 | Unsupported encoding |

## Verification
The assertions assume that the producer keeps its opcode and function fields at known values on every cycle where `in_valid` is high. The checker captures those fields at each handshake to tell which kind of result it holds. They also assume that `out_ready` is never unknown once reset is released. The bench drives every input from a task at the falling edge and holds all fields at defined values even when nothing is offered. It only ever offers encodings that are either listed in the requirements or picked on purpose as unsupported. Random operands are drawn only for legal encodings, so the captured kind always matches an encoding the requirements define.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_REG    = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI   = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADDIU  = 6'd9;
  localparam logic [OPC_W-1:0] OPC_SLTI   = 6'd10;
  localparam logic [OPC_W-1:0] OPC_SLTIU  = 6'd11;
  localparam logic [OPC_W-1:0] OPC_ANDI   = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI    = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI   = 6'd14;
  localparam logic [OPC_W-1:0] OPC_UPPER  = 6'd15;

  // function codes for register-register operations
  localparam logic [FN_W-1:0] FN_SHL_K  = 6'd0;
  localparam logic [FN_W-1:0] FN_SHR_K  = 6'd2;
  localparam logic [FN_W-1:0] FN_SAR_K  = 6'd3;
  localparam logic [FN_W-1:0] FN_SHL_V  = 6'd4;
  localparam logic [FN_W-1:0] FN_SHR_V  = 6'd6;
  localparam logic [FN_W-1:0] FN_SAR_V  = 6'd7;
  localparam logic [FN_W-1:0] FN_ADD_T  = 6'd32;
  localparam logic [FN_W-1:0] FN_ADD_W  = 6'd33;
  localparam logic [FN_W-1:0] FN_SUB_T  = 6'd34;
  localparam logic [FN_W-1:0] FN_SUB_W  = 6'd35;
  localparam logic [FN_W-1:0] FN_AND    = 6'd36;
  localparam logic [FN_W-1:0] FN_OR     = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR    = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR    = 6'd39;
  localparam logic [FN_W-1:0] FN_LT_S   = 6'd42;
  localparam logic [FN_W-1:0] FN_LT_U   = 6'd43;

  typedef enum logic [3:0] {
    XO_SHL, XO_SHR, XO_SAR, XO_ADD, XO_SUB, XO_AND, XO_OR,
    XO_XOR, XO_NOR, XO_LTS, XO_LTU, XO_BAD
  } xop_e;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FN_W-1:0]   funct,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  output xop_e              op,
  output logic              trap_en,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [SH_W-1:0]   shift_amt
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx, imm_zx, imm_hi;

  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_zx = {{EXT_W{1'b0}}, imm};
  assign imm_hi = {imm, {EXT_W{1'b0}}};

  always_comb begin
    op        = XO_BAD;
    trap_en   = 1'b0;
    opnd_a    = rs_val;
    opnd_b    = rt_val;
    shift_amt = shamt;
    if (opcode == OPC_REG) begin
      unique case (funct)
        FN_SHL_K: op = XO_SHL;
        FN_SHR_K: op = XO_SHR;
        FN_SAR_K: op = XO_SAR;
        FN_SHL_V: begin op = XO_SHL; shift_amt = rs_val[SH_W-1:0]; end
        FN_SHR_V: begin op = XO_SHR; shift_amt = rs_val[SH_W-1:0]; end
        FN_SAR_V: begin op = XO_SAR; shift_amt = rs_val[SH_W-1:0]; end
        FN_ADD_T: begin op = XO_ADD; trap_en = 1'b1; end
        FN_ADD_W: op = XO_ADD;
        FN_SUB_T: begin op = XO_SUB; trap_en = 1'b1; end
        FN_SUB_W: op = XO_SUB;
        FN_AND:   op = XO_AND;
        FN_OR:    op = XO_OR;
        FN_XOR:   op = XO_XOR;
        FN_NOR:   op = XO_NOR;
        FN_LT_S:  op = XO_LTS;
        FN_LT_U:  op = XO_LTU;
        default:  op = XO_BAD;
      endcase
    end else begin
      unique case (opcode)
        OPC_ADDI:  begin op = XO_ADD; trap_en = 1'b1; opnd_b = imm_sx; end
        OPC_ADDIU: begin op = XO_ADD; opnd_b = imm_sx; end
        OPC_SLTI:  begin op = XO_LTS; opnd_b = imm_sx; end
        OPC_SLTIU: begin op = XO_LTU; opnd_b = imm_sx; end
        OPC_ANDI:  begin op = XO_AND; opnd_b = imm_zx; end
        OPC_ORI:   begin op = XO_OR;  opnd_b = imm_zx; end
        OPC_XORI:  begin op = XO_XOR; opnd_b = imm_zx; end
        OPC_UPPER: begin op = XO_OR;  opnd_a = '0; opnd_b = imm_hi; end
        default:   op = XO_BAD;
      endcase
    end
  end
endmodule

// File: rtl/int_exec_shift.sv
module int_exec_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [SH_W-1:0]   amt,
  input  logic              dir_right,
  input  logic              arith,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] stage [0:SH_W];

  assign stage[0] = value;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    logic [DATA_W-1:0] moved;
    always_comb begin
      if (!dir_right)  moved = stage[i] << STEP;
      else if (arith)  moved = DATA_W'($signed(stage[i]) >>> STEP);
      else             moved = stage[i] >> STEP;
    end
    assign stage[i+1] = amt[i] ? moved : stage[i];
  end

  assign result = stage[SH_W];
endmodule

// File: rtl/int_exec_arith.sv
module int_exec_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic              sum_ovf,
  output logic              diff_ovf,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int MSB = DATA_W - 1;

  assign sum  = a + b;
  assign diff = a - b;

  // same-sign inputs, other-sign sum
  assign sum_ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  // opposite-sign inputs, difference flips away from a
  assign diff_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);

  assign lt_signed   = $signed(a) < $signed(b);
  assign lt_unsigned = a < b;
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [FN_W-1:0]   in_funct,
  input  logic [SH_W-1:0]   in_shamt,
  input  logic [DATA_W-1:0] in_rs_val,
  input  logic [DATA_W-1:0] in_rt_val,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_ovf,
  output logic              out_illegal
);
  xop_e              dec_op;
  logic              dec_trap;
  logic [DATA_W-1:0] opnd_a, opnd_b, shift_res, sum, diff;
  logic [SH_W-1:0]   shift_amt;
  logic              sum_ovf, diff_ovf, lt_s, lt_u;
  logic [DATA_W-1:0] res_d;
  logic              ovf_d, take;

  int_exec_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dec (
    .opcode(in_opcode), .funct(in_funct), .shamt(in_shamt),
    .rs_val(in_rs_val), .rt_val(in_rt_val), .imm(in_imm),
    .op(dec_op), .trap_en(dec_trap), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shift_amt(shift_amt)
  );

  int_exec_shift #(.DATA_W(DATA_W)) u_shift (
    .value(in_rt_val), .amt(shift_amt),
    .dir_right(dec_op != XO_SHL), .arith(dec_op == XO_SAR),
    .result(shift_res)
  );

  int_exec_arith #(.DATA_W(DATA_W)) u_arith (
    .a(opnd_a), .b(opnd_b), .sum(sum), .diff(diff),
    .sum_ovf(sum_ovf), .diff_ovf(diff_ovf),
    .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    unique case (dec_op)
      XO_SHL, XO_SHR, XO_SAR: res_d = shift_res;
      XO_ADD: begin res_d = sum;  ovf_d = dec_trap & sum_ovf;  end
      XO_SUB: begin res_d = diff; ovf_d = dec_trap & diff_ovf; end
      XO_AND: res_d = opnd_a & opnd_b;
      XO_OR:  res_d = opnd_a | opnd_b;
      XO_XOR: res_d = opnd_a ^ opnd_b;
      XO_NOR: res_d = ~(opnd_a | opnd_b);
      XO_LTS: res_d = {{(DATA_W-1){1'b0}}, lt_s};
      XO_LTU: res_d = {{(DATA_W-1){1'b0}}, lt_u};
      default: res_d = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_ovf     <= 1'b0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_result  <= res_d;
      out_ovf     <= ovf_d;
      out_illegal <= (dec_op == XO_BAD);
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [5:0]        in_opcode,
  input logic [5:0]        in_funct,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_ovf,
  input logic              out_illegal
);
  logic trap_kind_q, cmp_kind_q, upper_kind_q;
  logic reg_fmt;

  assign reg_fmt = (in_opcode == 6'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_kind_q  <= 1'b0;
      cmp_kind_q   <= 1'b0;
      upper_kind_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      trap_kind_q  <= (reg_fmt && (in_funct == 6'd32 || in_funct == 6'd34)) ||
                      (in_opcode == 6'd8);
      cmp_kind_q   <= (reg_fmt && (in_funct == 6'd42 || in_funct == 6'd43)) ||
                      (in_opcode == 6'd10) || (in_opcode == 6'd11);
      upper_kind_q <= (in_opcode == 6'd15);
    end
  end

  p_take_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
                                $stable(out_ovf) && $stable(out_illegal));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !trap_kind_q |-> !out_ovf);

  p_cmp_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cmp_kind_q |-> out_result[DATA_W-1:1] == '0);

  p_upper_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && upper_kind_q |-> out_result[DATA_W/2-1:0] == '0);

  p_illegal_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0 && !out_ovf);
endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_funct(in_funct), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_ovf(out_ovf),
  .out_illegal(out_illegal)
);

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_opcode = '0;
  logic [5:0]  in_funct = '0;
  logic [4:0]  in_shamt = '0;
  logic [31:0] in_rs_val = '0;
  logic [31:0] in_rt_val = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_ovf;
  logic        out_illegal;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  int_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_funct(in_funct), .in_shamt(in_shamt),
    .in_rs_val(in_rs_val), .in_rt_val(in_rt_val), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_ovf(out_ovf), .out_illegal(out_illegal)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string tag, logic [34:0] got, logic [34:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // behavioural reference built from the requirement text
  function automatic logic [33:0] ref_exec(logic [5:0] op, logic [5:0] fn,
      logic [4:0] sh, logic [31:0] a, logic [31:0] b, logic [15:0] imm);
    logic [31:0] se, ze, r;
    logic v, il;
    se = {{16{imm[15]}}, imm};
    ze = {16'h0, imm};
    r = '0; v = 1'b0; il = 1'b0;
    if (op == 6'd0) begin
      case (fn)
        6'd0:  r = b << sh;
        6'd2:  r = b >> sh;
        6'd3:  r = 32'($signed(b) >>> sh);
        6'd4:  r = b << a[4:0];
        6'd6:  r = b >> a[4:0];
        6'd7:  r = 32'($signed(b) >>> a[4:0]);
        6'd32: begin r = a + b; v = (a[31] == b[31]) && (r[31] != a[31]); end
        6'd33: r = a + b;
        6'd34: begin r = a - b; v = (a[31] != b[31]) && (r[31] != a[31]); end
        6'd35: r = a - b;
        6'd36: r = a & b;
        6'd37: r = a | b;
        6'd38: r = a ^ b;
        6'd39: r = ~(a | b);
        6'd42: r = {31'b0, $signed(a) < $signed(b)};
        6'd43: r = {31'b0, a < b};
        default: il = 1'b1;
      endcase
    end else begin
      case (op)
        6'd8:  begin r = a + se; v = (a[31] == se[31]) && (r[31] != a[31]); end
        6'd9:  r = a + se;
        6'd10: r = {31'b0, $signed(a) < $signed(se)};
        6'd11: r = {31'b0, a < se};
        6'd12: r = a & ze;
        6'd13: r = a | ze;
        6'd14: r = a ^ ze;
        6'd15: r = {imm, 16'h0};
        default: il = 1'b1;
      endcase
    end
    return {il, v, r};
  endfunction

  task automatic drive(logic [5:0] op, logic [5:0] fn, logic [4:0] sh,
                       logic [31:0] a, logic [31:0] b, logic [15:0] imm);
    in_opcode = op; in_funct = fn; in_shamt = sh;
    in_rs_val = a; in_rt_val = b; in_imm = imm;
  endtask

  task automatic exec_chk(string tag, logic [5:0] op, logic [5:0] fn,
      logic [4:0] sh, logic [31:0] a, logic [31:0] b, logic [15:0] imm,
      logic [31:0] er, logic eo, logic ei);
    @(negedge clk);
    drive(op, fn, sh, a, b, imm);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, out_illegal, out_ovf, out_result}, {1'b1, ei, eo, er});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", {33'b0, out_valid, in_ready}, 35'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {33'b0, out_valid, in_ready}, 35'b01);
  endtask

  task automatic t_fixed_shifts();
    exec_chk("R4 sll 31", 6'd0, 6'd0, 5'd31, 32'hFFFF_FFFF, 32'h1, 16'h0, 32'h8000_0000, 1'b0, 1'b0);
    exec_chk("R4 srl 4",  6'd0, 6'd2, 5'd4,  32'h0, 32'h8000_0000, 16'h0, 32'h0800_0000, 1'b0, 1'b0);
    exec_chk("R4 sra 4",  6'd0, 6'd3, 5'd4,  32'h0, 32'h8000_0000, 16'h0, 32'hF800_0000, 1'b0, 1'b0);
    exec_chk("R4 sra 0",  6'd0, 6'd3, 5'd0,  32'h0, 32'h8000_0001, 16'h0, 32'h8000_0001, 1'b0, 1'b0);
  endtask

  task automatic t_var_shifts();
    exec_chk("R5 sllv high rs bits ignored", 6'd0, 6'd4, 5'd9, 32'h0000_0024, 32'h1, 16'h0, 32'h10, 1'b0, 1'b0);
    exec_chk("R5 srlv 31", 6'd0, 6'd6, 5'd0, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 32'h1, 1'b0, 1'b0);
    exec_chk("R5 srav 31", 6'd0, 6'd7, 5'd3, 32'h0000_001F, 32'h8000_0000, 16'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_addsub();
    exec_chk("R6 add plain",  6'd0, 6'd32, 5'd0, 32'd5, 32'd7, 16'h0, 32'd12, 1'b0, 1'b0);
    exec_chk("R6 sub negative", 6'd0, 6'd34, 5'd0, 32'd3, 32'd5, 16'h0, 32'hFFFF_FFFE, 1'b0, 1'b0);
    exec_chk("R6 addu wrap", 6'd0, 6'd33, 5'd0, 32'hFFFF_FFFF, 32'h2, 16'h0, 32'h1, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    exec_chk("R3 add pos ovf",  6'd0, 6'd32, 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h8000_0000, 1'b1, 1'b0);
    exec_chk("R3 addu no trap", 6'd0, 6'd33, 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h8000_0000, 1'b0, 1'b0);
    exec_chk("R3 add neg ovf",  6'd0, 6'd32, 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 32'h7FFF_FFFF, 1'b1, 1'b0);
    exec_chk("R3 sub ovf",      6'd0, 6'd34, 5'd0, 32'h8000_0000, 32'h1, 16'h0, 32'h7FFF_FFFF, 1'b1, 1'b0);
    exec_chk("R3 subu no trap", 6'd0, 6'd35, 5'd0, 32'h8000_0000, 32'h1, 16'h0, 32'h7FFF_FFFF, 1'b0, 1'b0);
    exec_chk("R3 sub ovf pos",  6'd0, 6'd34, 5'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'h8000_0000, 1'b1, 1'b0);
    exec_chk("R3 addi ovf",     6'd8, 6'd0, 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, 32'h8000_0000, 1'b1, 1'b0);
    exec_chk("R3 addiu no trap", 6'd9, 6'd0, 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, 32'h8000_0000, 1'b0, 1'b0);
    exec_chk("R3 addi neg ovf", 6'd8, 6'd0, 5'd0, 32'h8000_0000, 32'h0, 16'hFFFF, 32'h7FFF_FFFF, 1'b1, 1'b0);
    exec_chk("R3 slt no trap",  6'd0, 6'd42, 5'd0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_logic();
    exec_chk("R7 and", 6'd0, 6'd36, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 32'h00F0_000F, 1'b0, 1'b0);
    exec_chk("R7 or",  6'd0, 6'd37, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 32'hFFF0_0FFF, 1'b0, 1'b0);
    exec_chk("R7 xor", 6'd0, 6'd38, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 32'hFF00_0FF0, 1'b0, 1'b0);
    exec_chk("R7 nor", 6'd0, 6'd39, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 32'h000F_F000, 1'b0, 1'b0);
  endtask

  task automatic t_compare();
    exec_chk("R8 slt min<1",   6'd0, 6'd42, 5'd0, 32'h8000_0000, 32'h1, 16'h0, 32'h1, 1'b0, 1'b0);
    exec_chk("R8 sltu min<1",  6'd0, 6'd43, 5'd0, 32'h8000_0000, 32'h1, 16'h0, 32'h0, 1'b0, 1'b0);
    exec_chk("R8 slt 1<min",   6'd0, 6'd42, 5'd0, 32'h1, 32'h8000_0000, 16'h0, 32'h0, 1'b0, 1'b0);
    exec_chk("R8 sltu 1<min",  6'd0, 6'd43, 5'd0, 32'h1, 32'h8000_0000, 16'h0, 32'h1, 1'b0, 1'b0);
    exec_chk("R8 slt equal",   6'd0, 6'd42, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_imm_sext();
    exec_chk("R9 addiu -1", 6'd9,  6'd0, 5'd0, 32'd10, 32'h0, 16'hFFFF, 32'd9, 1'b0, 1'b0);
    exec_chk("R9 slti -2<-1", 6'd10, 6'd0, 5'd0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 32'h1, 1'b0, 1'b0);
    exec_chk("R9 sltiu sext", 6'd11, 6'd0, 5'd0, 32'd5, 32'h0, 16'hFFFF, 32'h1, 1'b0, 1'b0);
    exec_chk("R9 sltiu max",  6'd11, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_imm_zext();
    exec_chk("R10 andi", 6'd12, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001, 32'h0000_8001, 1'b0, 1'b0);
    exec_chk("R10 ori",  6'd13, 6'd0, 5'd0, 32'h1234_0000, 32'h0, 16'hFFFF, 32'h1234_FFFF, 1'b0, 1'b0);
    exec_chk("R10 xori", 6'd14, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8000, 32'hFFFF_7FFF, 1'b0, 1'b0);
  endtask

  task automatic t_upper();
    exec_chk("R11 lui rs ignored", 6'd15, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 32'hBEEF_0000, 1'b0, 1'b0);
    exec_chk("R11 lui zero", 6'd15, 6'd0, 5'd0, 32'h1234_5678, 32'h0, 16'h0000, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_illegal();
    exec_chk("R12 funct 1",  6'd0,  6'd1,  5'd7, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0, 1'b0, 1'b1);
    exec_chk("R12 funct 24", 6'd0,  6'd24, 5'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 32'h0, 1'b0, 1'b1);
    exec_chk("R12 opcode 32", 6'd32, 6'd32, 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0001, 32'h0, 1'b0, 1'b1);
    exec_chk("R12 opcode 2",  6'd2,  6'd0,  5'd0, 32'hFFFF_FFFF, 32'h1, 16'hFFFF, 32'h0, 1'b0, 1'b1);
    exec_chk("R12 opcode 63", 6'd63, 6'd0,  5'd0, 32'h1, 32'h1, 16'h1, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    drive(6'd0, 6'd33, 5'd0, 32'd100, 32'd23, 16'h0);
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 first result", {out_valid, out_illegal, out_ovf, out_result}, {3'b100, 32'd123});
    check("R2 ready low when full", {34'b0, in_ready}, 35'b0);
    drive(6'd0, 6'd35, 5'd0, 32'd100, 32'd23, 16'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 held under stall", {out_valid, out_illegal, out_ovf, out_result}, {3'b100, 32'd123});
      check("R2 ready stays low", {34'b0, in_ready}, 35'b0);
    end
    out_ready = 1'b1;
    #1;
    check("R2 ready follows out_ready", {34'b0, in_ready}, 35'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second result same edge", {out_valid, out_illegal, out_ovf, out_result}, {3'b100, 32'd77});
    @(negedge clk);
    check("R2 drained", {34'b0, out_valid}, 35'b0);
  endtask

  task automatic t_random();
    logic [5:0] rfn [16] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7, 6'd32, 6'd33,
                             6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd39, 6'd42, 6'd43};
    logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op, fn;
      logic [4:0] sh;
      logic [31:0] a, b;
      logic [15:0] imm;
      logic [33:0] e;
      fn = rfn[$urandom_range(0, 15)];
      op = ($urandom_range(0, 1) == 0) ? 6'd0 : 6'($urandom_range(8, 15));
      sh = 5'($urandom);
      a  = ($urandom_range(0, 2) == 0) ? corner[$urandom_range(0, 4)] : $urandom;
      b  = ($urandom_range(0, 2) == 0) ? corner[$urandom_range(0, 4)] : $urandom;
      imm = 16'($urandom);
      e = ref_exec(op, fn, sh, a, b, imm);
      exec_chk("random mix R6 R9 R10", op, fn, sh, a, b, imm, e[31:0], e[32], e[33]);
    end
  endtask

  initial begin
    t_reset();
    t_fixed_shifts();
    t_var_shifts();
    t_addsub();
    t_overflow();
    t_logic();
    t_compare();
    t_imm_sext();
    t_imm_zext();
    t_upper();
    t_illegal();
    t_backpressure();
    t_random();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule